// File: doc/BRIEF.md
# Transaction Status Flag Register

This block holds the result of the most recent bus transaction on the host side. The packet engine reports each transaction through single-cycle event strobes. The register turns them into three readable items: a two-bit handshake code, a sticky bit-stuffing error flag and a sticky timeout flag. Software reads all three as one status byte.

Software clears an error flag by writing 0 to its bit. Writing 1 leaves the flag as it is. The handshake field is status only and cannot be written. It changes only when a transaction or a start-of-frame transfer finishes. A controller-level reset input, held high, returns every item to its idle value.

Top module: `txn_status_reg`

## Requirements
- R1: The handshake field is `rd_data[1:0]`, coded 00 = ACK, 01 = NAK, 10 = STALL and 11 = NULL. A cycle with `evt_done` and `evt_hs_valid` both high, and no error strobe, loads `hs_code` into it. The new value is visible from the next clock edge.
- R2: The handshake field loads NULL (11) in three cases: `evt_done` is high without `evt_hs_valid`; `evt_done` comes with `evt_stuff_err` or `evt_timeout` in the same cycle; or `evt_sof_done` is high.
- R3: The handshake field holds its value in every cycle without `evt_done` or `evt_sof_done`. A write to the register, or an `evt_hs_valid` without `evt_done`, does not change it.
- R4: `evt_stuff_err` sets the stuffing flag (`rd_data[3]`) and also sets the timeout flag (`rd_data[2]`).
- R5: `evt_timeout` sets only the timeout flag (`rd_data[2]`). The stuffing flag stays as it was.
- R6: A write with `wr_data[3]` = 0 clears the stuffing flag. A write with `wr_data[2]` = 0 clears the timeout flag. A write of 1 to either bit leaves that flag unchanged.
- R7: When a set event and a clearing write reach the same flag in the same clock cycle, the flag ends set.
- R8: While `ctl_rst` is high, the handshake field is NULL (11) and both flags are 0, and event strobes are ignored. The asynchronous `rst_n` gives the same state.
- R9: `rd_data[7:4]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_rst | input | 1 | Controller reset level, synchronous, active high |
| evt_done | input | 1 | Send or receive finished (one-cycle strobe) |
| evt_hs_valid | input | 1 | A handshake was received for this transaction |
| hs_code | input | 2 | Received handshake code (00 ACK, 01 NAK, 10 STALL) |
| evt_stuff_err | input | 1 | Bit-stuffing error detected |
| evt_timeout | input | 1 | Timeout detected |
| evt_sof_done | input | 1 | Start-of-frame token transfer finished |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | DW | Software write data |
| rd_data | output | DW | Status byte read by software |

## Verification
The handshake path is driven with each of the three received codes and then with completions that lack a handshake, that carry an error, or that are start-of-frame only. This separates loading `hs_code` from forcing NULL. Handshake strobes and writes are also applied without any completion strobe, which shows that the field updates only at the end of a transfer. On the flag side, stuffing errors and plain timeouts are applied separately to show the one-way coupling between them. Writes of 0, of 1 and of mixed patterns separate a clearing write from a write that keeps the flag. Set events that arrive with a clearing write in the same cycle, and events that arrive while `ctl_rst` is high, fix the two priority rules.

// File: rtl/txn_status_reg.sv
module txn_status_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_rst,
  input  logic          evt_done,
  input  logic          evt_hs_valid,
  input  logic [1:0]    hs_code,
  input  logic          evt_stuff_err,
  input  logic          evt_timeout,
  input  logic          evt_sof_done,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int TMO_BIT   = 2;
  localparam int STUFF_BIT = 3;
  localparam int PAD_W     = DW - 4;
  localparam logic [1:0] HS_NULL = 2'b11;

  logic [1:0] hs_q;
  logic       stuff_q, tmo_q;

  logic       any_err, hs_load, keep_stuff, keep_tmo, set_stuff, set_tmo;
  logic [1:0] hs_next;

  assign any_err    = evt_stuff_err | evt_timeout;
  assign hs_load    = evt_done | evt_sof_done;
  assign hs_next    = (evt_sof_done || !evt_hs_valid || any_err) ? HS_NULL : hs_code;
  assign set_stuff  = evt_stuff_err;
  assign set_tmo    = evt_stuff_err | evt_timeout;
  assign keep_stuff = !(wr_en && !wr_data[STUFF_BIT]);
  assign keep_tmo   = !(wr_en && !wr_data[TMO_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= HS_NULL;
      stuff_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else if (ctl_rst) begin
      hs_q    <= HS_NULL;
      stuff_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      if (hs_load) hs_q <= hs_next;
      stuff_q <= set_stuff | (stuff_q & keep_stuff);
      tmo_q   <= set_tmo   | (tmo_q   & keep_tmo);
    end
  end

  assign rd_data = {{PAD_W{1'b0}}, stuff_q, tmo_q, hs_q};

  AST_SOF_NULL:      assert property (@(posedge clk) disable iff (!rst_n)
                       evt_sof_done && !ctl_rst |=> rd_data[1:0] == HS_NULL);            // R2
  AST_HS_HOLD:       assert property (@(posedge clk) disable iff (!rst_n)
                       !evt_done && !evt_sof_done && !ctl_rst |=> $stable(rd_data[1:0])); // R3
  AST_STUFF_BOTH:    assert property (@(posedge clk) disable iff (!rst_n)
                       evt_stuff_err && !ctl_rst |=> rd_data[STUFF_BIT] && rd_data[TMO_BIT]); // R4
  AST_NO_SPUR_STUFF: assert property (@(posedge clk) disable iff (!rst_n)
                       !evt_stuff_err |=> !$rose(rd_data[STUFF_BIT]));                    // R5
  AST_SET_WINS:      assert property (@(posedge clk) disable iff (!rst_n)
                       evt_timeout && wr_en && !ctl_rst |=> rd_data[TMO_BIT]);            // R7
  AST_CTL_RST_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
                       ctl_rst |=> rd_data[3:0] == 4'b0011);                              // R8
  AST_PAD_ZERO:      assert property (@(posedge clk) disable iff (!rst_n)
                       rd_data[DW-1:4] == '0);                                            // R9
endmodule

// File: tb/txn_status_reg_tb.sv
module txn_status_reg_tb_top;
  logic       clk = 0, rst_n = 0, ctl_rst = 0;
  logic       evt_done = 0, evt_hs_valid = 0, evt_stuff_err = 0, evt_timeout = 0, evt_sof_done = 0;
  logic [1:0] hs_code = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  txn_status_reg #(.DW(8)) dut_i (.*);

  task automatic idle_all();
    evt_done = 0; evt_hs_valid = 0; evt_stuff_err = 0; evt_timeout = 0;
    evt_sof_done = 0; wr_en = 0; wr_data = 0; ctl_rst = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_all();
  endtask

  task automatic chk(string req, logic [7:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%02h expected=%02h", req, rd_data, exp);
    end
  endtask

  task automatic xfer(logic v, logic [1:0] c);
    evt_done = 1; evt_hs_valid = v; hs_code = c; tick();
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; tick();
  endtask

  task automatic t_reset();
    chk("R8", 8'h03);
    chk("R9", 8'h03);
  endtask

  task automatic t_codes();
    xfer(1, 2'b00); chk("R1", 8'h00);
    xfer(1, 2'b01); chk("R1", 8'h01);
    xfer(1, 2'b10); chk("R1", 8'h02);
    xfer(1, 2'b00); chk("R1", 8'h00);
  endtask

  task automatic t_null();
    xfer(0, 2'b01); chk("R2", 8'h03);
    xfer(1, 2'b01); chk("R1", 8'h01);
    evt_timeout = 1; xfer(1, 2'b10); chk("R2", 8'h07);
    wr(8'h00); chk("R6", 8'h03);
    xfer(1, 2'b10); chk("R1", 8'h02);
    evt_sof_done = 1; tick(); chk("R2", 8'h03);
    xfer(1, 2'b00); chk("R1", 8'h00);
    evt_stuff_err = 1; xfer(1, 2'b01); chk("R2", 8'h0F);
    wr(8'h00); chk("R6", 8'h03);
  endtask

  task automatic t_hold();
    xfer(1, 2'b01); chk("R1", 8'h01);
    tick(); tick(); chk("R3", 8'h01);
    evt_hs_valid = 1; hs_code = 2'b10; tick(); chk("R3", 8'h01);
    wr(8'h00); chk("R3", 8'h01);
    wr(8'hFF); chk("R3", 8'h01);
  endtask

  task automatic t_flags();
    evt_stuff_err = 1; tick(); chk("R4", 8'h0D);
    wr(8'h00); chk("R6", 8'h01);
    evt_timeout = 1; tick(); chk("R5", 8'h05);
    evt_stuff_err = 1; tick(); chk("R4", 8'h0D);
    wr(8'hFF); chk("R6", 8'h0D);
    wr(8'h04); chk("R6", 8'h05);
    wr(8'h08); chk("R6", 8'h01);
  endtask

  task automatic t_set_wins();
    evt_timeout = 1; wr_en = 1; wr_data = 8'h00; tick(); chk("R7", 8'h05);
    evt_stuff_err = 1; wr_en = 1; wr_data = 8'h00; tick(); chk("R7", 8'h0D);
    wr(8'h00); chk("R6", 8'h01);
  endtask

  task automatic t_ctl_rst();
    evt_stuff_err = 1; xfer(1, 2'b10); chk("R4", 8'h0F);
    xfer(1, 2'b10); chk("R1", 8'h0E);
    ctl_rst = 1; @(negedge clk); chk("R8", 8'h03);
    evt_stuff_err = 1; evt_timeout = 1; evt_done = 1; evt_hs_valid = 1; hs_code = 2'b01;
    @(negedge clk); chk("R8", 8'h03);
    idle_all(); tick(); chk("R8", 8'h03);
    xfer(1, 2'b01); chk("R1", 8'h01);
    rst_n = 0; #1; chk("R8", 8'h03);
    @(negedge clk); rst_n = 1; tick(); chk("R9", 8'h03);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: rd_data=%02h expected=completion", rd_data);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_codes();
    t_null();
    t_hold();
    t_flags();
    t_set_wins();
    t_ctl_rst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule